// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address sequence for a four-beat burst in a synchronous memory. A burst begins when either of two address strobes is sampled high. One strobe comes from the processor side and the other from the controller side. The strobe captures a starting address, and the registered output address takes that value on the next cycle.

After that, each clock edge on which the advance input is high moves the burst one beat forward. Only the low two bits of the address change. They follow one of two orderings. In interleaved ordering the start offset is XORed with the beat number. In linear ordering the beat number is added modulo four, so the offset wraps inside the aligned group of four. The ordering is chosen by a mode input, which is captured together with the starting address.

The upper address bits stay fixed for the whole burst. A registered flag marks the fourth beat. The memory array and the data path are outside this block.

Top module: `burst_seq_top`

## Requirements
- R1: While reset is high at a clock edge, the next output is `addr` = 0 and `last` = 0.
- R2: When `strb_proc` or `strb_ctrl` is high at an edge, `addr` equals the sampled `ld_addr` from the next cycle on, and `last` = 0 (beat 0).
- R3: With `mode` = 0 (interleaved) captured at the load, beat n has low bits = start_low XOR n.
- R4: With `mode` = 1 (linear) captured at the load, beat n has low bits = (start_low + n) mod 4.
- R5: Bits `addr[AW-1:2]` do not change between loads, whatever the low bits do.
- R6: An advance taken on beat 3 returns the burst to beat 0, which is the start address.
- R7: A strobe and `adv` in the same cycle perform the load only.
- R8: With no strobe and `adv` low, `addr` and `last` hold their values.
- R9: `last` is 1 exactly when the current beat index is 3.
- R10: `mode` is sampled only on a load; changing it in the middle of a burst has no effect on the order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| strb_proc | input | 1 | Processor-side address strobe |
| strb_ctrl | input | 1 | Controller-side address strobe |
| ld_addr | input | AW | Starting address |
| adv | input | 1 | Advance one beat |
| mode | input | 1 | 1 = linear, 0 = interleaved |
| addr | output | AW | Current burst address (registered) |
| last | output | 1 | Fourth-beat flag (registered) |

## Verification
Directed bursts start from each of the four low offsets in both modes. These separate the XOR ordering from the modular add: the two orderings agree for offset 0 and differ for odd offsets. Starting addresses with all upper bits set show whether a carry leaks out of the low bits on a wrap. Same-cycle strobe-and-advance cases and a mode flip in the middle of a burst test load priority and mode capture. A long random run mixes both strobes, idle gaps and advances, so that wrap-around past beat 3 and back-to-back loads are compared against a bench model.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int BEAT_W = 2;
  typedef logic [BEAT_W-1:0] beat_t;
  typedef enum logic {ORD_INTERLEAVE = 1'b0, ORD_LINEAR = 1'b1} order_e;
  localparam beat_t LAST_BEAT = beat_t'((1 << BEAT_W) - 1);
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  load,
  input  logic  step,
  output beat_t beat_q,
  output beat_t beat_d
);
  always_comb begin
    beat_d = beat_q;
    if (load)      beat_d = '0;
    else if (step) beat_d = beat_q + beat_t'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) beat_q <= '0;
    else     beat_q <= beat_d;
  end

  // R6: stepping past the final beat returns to beat zero
  a_r6_wrap: assert property (@(posedge clk) disable iff (rst)
    (beat_q == LAST_BEAT && step && !load) |=> (beat_q == '0));
  // R7: load wins over step
  a_r7_load_first: assert property (@(posedge clk) disable iff (rst)
    load |=> (beat_q == '0));
  // R8: no load and no step leaves the beat alone
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!load && !step) |=> $stable(beat_q));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_seq_pkg::*;
#(
  parameter bit LINEAR_EN = 1'b1
)(
  input  beat_t  start,
  input  beat_t  beat,
  input  order_e ord,
  output beat_t  low
);
  beat_t xor_low;
  assign xor_low = start ^ beat;

  generate
    if (LINEAR_EN) begin : g_both
      beat_t add_low;
      assign add_low = start + beat;
      assign low = (ord == ORD_LINEAR) ? add_low : xor_low;
    end else begin : g_xor_only
      assign low = xor_low;
    end
  endgenerate
endmodule

// File: rtl/burst_seq_top.sv
module burst_seq_top
  import burst_seq_pkg::*;
#(
  parameter int AW = 20
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          strb_proc,
  input  logic          strb_ctrl,
  input  logic [AW-1:0] ld_addr,
  input  logic          adv,
  input  logic          mode,
  output logic [AW-1:0] addr,
  output logic          last
);
  localparam int UW = AW - BEAT_W;

  logic          load;
  logic [UW-1:0] base_q, base_d;
  beat_t         start_q, start_d;
  order_e        ord_q, ord_d;
  beat_t         beat_q, beat_d, low_d;

  assign load = strb_proc | strb_ctrl;

  always_comb begin
    base_d  = base_q;
    start_d = start_q;
    ord_d   = ord_q;
    if (load) begin
      base_d  = ld_addr[AW-1:BEAT_W];
      start_d = ld_addr[BEAT_W-1:0];
      ord_d   = order_e'(mode);
    end
  end

  burst_beat_ctr u_ctr (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .step   (adv),
    .beat_q (beat_q),
    .beat_d (beat_d)
  );

  burst_order_map #(.LINEAR_EN(1'b1)) u_map (
    .start (start_d),
    .beat  (beat_d),
    .ord   (ord_d),
    .low   (low_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      start_q <= '0;
      ord_q   <= ORD_INTERLEAVE;
      addr    <= '0;
      last    <= 1'b0;
    end else begin
      base_q  <= base_d;
      start_q <= start_d;
      ord_q   <= ord_d;
      addr    <= {base_d, low_d};
      last    <= (beat_d == LAST_BEAT);
    end
  end

  // R2: a strobe presents the sampled address on the next cycle
  a_r2_load_addr: assert property (@(posedge clk) disable iff (rst)
    load |=> (addr == $past(ld_addr) && !last));
  // R5: upper bits are frozen between loads
  a_r5_upper_fixed: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(addr[AW-1:BEAT_W]));
  // R8: idle cycles keep the output
  a_r8_out_hold: assert property (@(posedge clk) disable iff (rst)
    (!load && !adv) |=> ($stable(addr) && $stable(last)));
  // R9: flag tracks the counter in the separate module
  a_r9_last_beat: assert property (@(posedge clk) disable iff (rst)
    last == (beat_q == LAST_BEAT));
endmodule

// File: tb/sim_burst_seq_top.sv
`timescale 1ns/1ps
module sim_burst_seq_top;
  localparam int AW = 20;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strb_proc = 0, strb_ctrl = 0, adv = 0, mode = 0;
  logic [AW-1:0] ld_addr = '0;
  logic [AW-1:0] addr;
  logic last;

  int n_cmp = 0, n_bad = 0;
  logic [AW-3:0] m_base = '0;
  logic [1:0] m_start = '0, m_beat = '0;
  logic m_mode = 0;

  always #2 clk = ~clk;

  burst_seq_top #(.AW(AW)) u0 (.*);

  function automatic logic [1:0] f_low(input logic [1:0] s, input logic [1:0] n, input logic md);
    return md ? 2'(s + n) : (s ^ n);
  endfunction

  task automatic check(input string req);
    logic [AW-1:0] exp_a;
    logic exp_l;
    exp_a = {m_base, f_low(m_start, m_beat, m_mode)};
    exp_l = (m_beat == 2'd3);
    n_cmp++;
    if (addr !== exp_a || last !== exp_l) begin
      n_bad++;
      $display("FAIL %s: addr=%h last=%b expected addr=%h last=%b", req, addr, last, exp_a, exp_l);
    end
  endtask

  task automatic cyc(input logic sp, input logic sc, input logic [AW-1:0] a,
                     input logic ad, input logic md, input string req);
    @(negedge clk);
    strb_proc = sp; strb_ctrl = sc; ld_addr = a; adv = ad; mode = md;
    @(posedge clk);
    if (sp || sc) begin
      m_base = a[AW-1:2]; m_start = a[1:0]; m_beat = 0; m_mode = md;
    end else if (ad) m_beat = m_beat + 2'd1;
    #1 check(req);
  endtask

  initial begin
    #150000;
    n_bad++;
    $display("FAIL watchdog: actual hang expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1");
    @(negedge clk) rst = 0;
    // R3 R4: every offset, both modes, four beats plus wrap (R6, R9)
    for (int md = 0; md < 2; md++)
      for (int s = 0; s < 4; s++) begin
        cyc(s[0], !s[0], {18'h3FFFF, 2'(s)}, 0, md[0], "R2");
        for (int b = 0; b < 4; b++) cyc(0, 0, '0, 1, 0, md ? "R4" : "R3");
        cyc(0, 0, '0, 0, 0, "R8");
      end
    // R5 R6: high bits all ones across a wrap, linear from offset 3
    cyc(1, 0, 20'hFFFFF, 0, 1, "R2");
    for (int b = 0; b < 6; b++) cyc(0, 0, '0, 1, 0, "R5");
    // R7: strobe with advance loads only
    cyc(0, 1, 20'h12345, 0, 0, "R2");
    cyc(0, 0, '0, 1, 0, "R3");
    cyc(1, 0, 20'h0ABC6, 1, 1, "R7");
    // R10: mode flip mid burst ignored
    cyc(0, 0, '0, 1, 0, "R10");
    cyc(0, 0, '0, 1, 0, "R10");
    cyc(0, 0, '0, 1, 1, "R10");
    // random mix
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] r;
      r = 4'($urandom);
      cyc(r[0] && r[1] && r[2], r[3] && r[1] && !r[2], AW'($urandom),
          r[2] | r[3], 1'($urandom), "R9");
    end
    // R1: reset returns to zero
    @(negedge clk) rst = 1;
    @(posedge clk);
    m_base = '0; m_start = '0; m_beat = '0; m_mode = 0;
    #1 check("R1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule